// File: doc/BRIEF.md
# Configuration Address Translator

This block claims a 4 MiB window of the CPU memory map and converts each access that falls inside it into a compact configuration-space access. The CPU selects a target device by setting a single address bit from a run of select bits (one-hot). The block turns the lowest such bit into a binary device number and forwards the access to a downstream configuration data port.

The forwarded address is the register offset (the low address bits, unchanged) with the device number placed directly above it. Accesses of 1, 2 or 4 bytes are carried in little-endian lanes: writes get byte enables and lane-aligned data, and reads are shifted down and zero-extended. Addresses outside the window are answered at once as misses and never reach the downstream port.

The upstream side is a valid/ready request with a one-cycle response pulse. Only one request is in flight at a time.

Top module: `cfg_addr_xlat`

## Requirements
- R1: Only addresses from 0x8080_0000 up to but not including 0x80C0_0000 are claimed. Any other address is accepted and answered on the next cycle with resp_hit=0 and resp_rdata=0, and it makes no downstream access.
- R2: The device number is the index of the lowest set bit among address bits 11 to 21, with bit 11 giving device 0 and bit 21 giving device 10.
- R3: If none of address bits 11 to 21 is set, the device number is 11.
- R4: When several select bits are set, only the lowest one counts. An access with extra higher select bits reaches the same downstream location as the access with the lowest bit alone.
- R5: cfg_addr[10:0] equals request address bits 10:0, and cfg_addr[14:11] holds the device number.
- R6: req_size encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. The byte lane is addr[1:0] for 1 byte, {addr[1],0} for 2 bytes and 0 for 4 bytes. A write drives cfg_be as 1, 3 or F shifted left by the lane, and drives cfg_wdata as req_wdata shifted left by 8 times the lane, so that request byte 0 lands in that lane.
- R7: A read returns cfg_rdata shifted right by 8 times the lane and masked to the access width, zero-extended to 32 bits. A claimed write returns resp_rdata=0 with resp_hit=1.
- R8: While a claimed request is outstanding, req_ready is low. cfg_valid, cfg_addr, cfg_be and cfg_wdata stay stable until cfg_ready is high.
- R9: resp_valid pulses with resp_hit=1 in the cycle after the cfg_valid/cfg_ready handshake.
- R10: During and right after reset, req_ready is high and cfg_valid and resp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | CPU byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Access width code |
| req_wdata | input | 32 | Write data, least significant byte first |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Address was inside the window |
| resp_rdata | output | 32 | Read data, zero-extended |
| cfg_valid | output | 1 | Downstream request valid |
| cfg_ready | input | 1 | Downstream accepts the request |
| cfg_addr | output | 15 | Device number and register offset |
| cfg_write | output | 1 | Downstream write |
| cfg_be | output | 4 | Downstream byte enables |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_rdata | input | 32 | Downstream read data, valid during the handshake |

## Verification
The address patterns are chosen to tell the encoder's cases apart:
- Every single select bit in turn confirms the bit-to-number mapping.
- An address with no select bit separates the "none set" fallback from device 0.
- Addresses with several select bits set, read back through the single-bit alias, show that higher bits are ignored.

Byte and halfword accesses at every lane tell a correct lane shift from a wrong one, because the surrounding bytes keep their earlier values. The addresses just below and just above the window show where the claim boundary lies. Downstream stalls of zero, one and three cycles separate the hold behaviour from the response timing.

// File: rtl/cfg_addr_xlat.sv
module cfg_addr_xlat #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_BITS = 22,
  parameter int SEL_LO = 11,
  parameter int SEL_N = 11,
  localparam int DEV_W = $clog2(SEL_N + 1),
  localparam int CFG_AW = SEL_LO + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [31:0]       resp_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic              cfg_write,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_rdata
);
  logic             busy;
  logic [1:0]       size_q, lane_q;
  logic [DEV_W-1:0] dev;
  logic [1:0]       lane;
  logic             hit;
  logic [3:0]       be;
  logic [31:0]      rd_shift;

  assign hit = req_addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS];

  always_comb begin
    dev = DEV_W'(SEL_N);
    for (int i = SEL_N - 1; i >= 0; i--)
      if (req_addr[SEL_LO + i]) dev = DEV_W'(i);
  end

  always_comb begin
    case (req_size)
      2'd0:    begin lane = req_addr[1:0];        be = 4'b0001 << req_addr[1:0]; end
      2'd1:    begin lane = {req_addr[1], 1'b0};  be = 4'b0011 << {req_addr[1], 1'b0}; end
      default: begin lane = 2'd0;                 be = 4'hF; end
    endcase
  end

  assign req_ready = !busy;
  assign cfg_valid = busy;
  assign rd_shift  = cfg_rdata >> {lane_q, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      cfg_addr   <= '0;
      cfg_write  <= 1'b0;
      cfg_be     <= '0;
      cfg_wdata  <= '0;
      size_q     <= '0;
      lane_q     <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (req_valid && !busy) begin
        if (hit) begin
          busy      <= 1'b1;
          cfg_addr  <= {dev, req_addr[SEL_LO-1:0]};
          cfg_write <= req_write;
          cfg_be    <= be;
          cfg_wdata <= req_wdata << {lane, 3'b000};
          size_q    <= req_size;
          lane_q    <= lane;
        end else begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b0;
          resp_rdata <= '0;
        end
      end else if (busy && cfg_ready) begin
        busy       <= 1'b0;
        resp_valid <= 1'b1;
        resp_hit   <= 1'b1;
        if (cfg_write)           resp_rdata <= '0;
        else if (size_q == 2'd0) resp_rdata <= {24'd0, rd_shift[7:0]};
        else if (size_q == 2'd1) resp_rdata <= {16'd0, rd_shift[15:0]};
        else                     resp_rdata <= rd_shift;
      end
    end
  end
endmodule

// File: rtl/cfg_addr_xlat_chk.sv
module cfg_addr_xlat_chk #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_BITS = 22,
  parameter int CFG_AW = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [31:0]       req_addr,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata
);
  logic in_win;
  assign in_win = ({32'd0, req_addr} >= {32'd0, WIN_BASE}) &&
                  ({32'd0, req_addr} < ({32'd0, WIN_BASE} + (64'd1 << WIN_BITS)));

  p_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !in_win |=> resp_valid && !resp_hit && !cfg_valid);

  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_be == 4'hF) || ($countones(cfg_be) == 1) ||
                  (cfg_be == 4'b0011) || (cfg_be == 4'b1100));

  p_single_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !req_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) &&
                                $stable(cfg_be) && $stable(cfg_wdata));

  p_resp_after_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> resp_valid && resp_hit);

  always @(posedge clk)
    if (!rst_n) p_reset_r10: assert (req_ready && !cfg_valid && !resp_valid);
endmodule

bind cfg_addr_xlat cfg_addr_xlat_chk #(
  .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS), .CFG_AW(CFG_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata)
);

// File: tb/cfg_addr_xlat_test.sv
module cfg_addr_xlat_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [1:0] req_size = 0;
  logic req_ready, resp_valid, resp_hit, cfg_valid, cfg_write;
  logic [31:0] resp_rdata, cfg_wdata;
  logic [31:0] cfg_rdata = 0;
  logic cfg_ready = 0;
  logic [14:0] cfg_addr;
  logic [3:0] cfg_be;

  int checks = 0, errors = 0, hs_count = 0, stall = 0, stall_cnt = 0;
  logic [31:0] stub_mem [int];
  logic [31:0] ref_mem [int];
  logic hs_d = 0;
  logic [14:0] e_addr; logic [3:0] e_be; logic [31:0] e_wdata; logic e_wr;
  string e_tag;

  always #5 clk = ~clk;

  cfg_addr_xlat uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    hs_d = rst_n && cfg_valid && cfg_ready;
    if (hs_d) begin
      hs_count++;
      if (cfg_write) begin
        logic [31:0] w = stub_mem.exists(int'(cfg_addr >> 2)) ? stub_mem[int'(cfg_addr >> 2)] : 0;
        for (int b = 0; b < 4; b++) if (cfg_be[b]) w[8*b +: 8] = cfg_wdata[8*b +: 8];
        stub_mem[int'(cfg_addr >> 2)] = w;
      end
    end
  end

  always @(negedge clk) begin
    if (hs_d) chk(resp_valid && resp_hit, "R9", "resp one cycle after handshake", {30'd0, resp_valid, resp_hit}, 32'd3);
    if (cfg_valid && req_ready) chk(0, "R8", "ready high while outstanding", 1, 0);
    if (cfg_valid) begin
      if (stall_cnt < stall) begin cfg_ready = 0; stall_cnt++; end
      else cfg_ready = 1;
      cfg_rdata = stub_mem.exists(int'(cfg_addr >> 2)) ? stub_mem[int'(cfg_addr >> 2)] : 0;
      chk(cfg_addr[14:11] == e_addr[14:11], e_tag, "device number", {28'd0, cfg_addr[14:11]}, {28'd0, e_addr[14:11]});
      chk(cfg_addr[10:0] == e_addr[10:0], "R5", "register offset", {21'd0, cfg_addr[10:0]}, {21'd0, e_addr[10:0]});
      if (e_wr) begin
        chk(cfg_be == e_be, "R6", "byte enables", {28'd0, cfg_be}, {28'd0, e_be});
        for (int b = 0; b < 4; b++)
          if (e_be[b]) chk(cfg_wdata[8*b +: 8] == e_wdata[8*b +: 8], "R6", "write lane", cfg_wdata, e_wdata);
      end
    end else begin
      cfg_ready = 0; stall_cnt = 0;
    end
  end

  function automatic logic [3:0] dev_of(input logic [31:0] a);
    for (int i = 0; i < 11; i++) if (a[11 + i]) return 4'(i);
    return 4'd11;
  endfunction

  task automatic access(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                        input logic [31:0] wd, input string tag);
    bit inwin = (a >= 32'h8080_0000) && (a < 32'h80C0_0000);
    logic [1:0] ln = (sz == 0) ? a[1:0] : (sz == 1) ? {a[1], 1'b0} : 2'd0;
    logic [3:0] bm = (sz == 0) ? 4'b0001 : (sz == 1) ? 4'b0011 : 4'hF;
    logic [31:0] exp_rd = 0, word;
    int key, hs0 = hs_count, n = 0;
    e_addr = {dev_of(a), a[10:0]}; e_be = bm << ln; e_wdata = wd << (8 * ln);
    e_wr = wr; e_tag = tag;
    key = int'(e_addr >> 2);
    word = ref_mem.exists(key) ? ref_mem[key] : 0;
    if (inwin) begin
      if (wr) begin
        for (int b = 0; b < 4; b++) if (e_be[b]) word[8*b +: 8] = e_wdata[8*b +: 8];
        ref_mem[key] = word;
      end else begin
        exp_rd = word >> (8 * ln);
        if (sz == 0) exp_rd &= 32'hFF; else if (sz == 1) exp_rd &= 32'hFFFF;
      end
    end
    @(negedge clk);
    req_addr = a; req_write = wr; req_size = sz; req_wdata = wd; req_valid = 1;
    chk(req_ready, "R8", "ready when idle", {31'd0, req_ready}, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    while (!resp_valid && n < 60) begin @(negedge clk); n++; end
    chk(resp_valid && resp_hit == inwin, inwin ? tag : "R1", "response hit", {31'd0, resp_hit}, {31'd0, inwin});
    chk(resp_rdata == exp_rd, wr ? "R7" : "R7", "response data", resp_rdata, exp_rd);
    if (!inwin) chk(hs_count == hs0, "R1", "no downstream access on miss", hs_count, hs0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !cfg_valid && !resp_valid, "R10", "reset state",
        {29'd0, req_ready, cfg_valid, resp_valid}, 32'd4);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !cfg_valid && !resp_valid, "R10", "after reset",
        {29'd0, req_ready, cfg_valid, resp_valid}, 32'd4);
    for (int d = 0; d < 11; d++) begin
      stall = d % 4;
      access(32'h8080_0000 | (32'd1 << (11 + d)) | 32'h40, 1, 2, 32'hA500_0000 + d, "R2");
    end
    access(32'h8080_0044, 1, 2, 32'h1234_5678, "R3");
    for (int d = 0; d < 11; d++)
      access(32'h8080_0000 | (32'd1 << (11 + d)) | 32'h40, 0, 2, 0, "R2");
    access(32'h8080_0044, 0, 2, 0, "R3");
    stall = 1;
    access(32'h8080_0000 | (32'd1 << 13) | (32'd1 << 20) | 32'h80, 1, 2, 32'hCAFE_F00D, "R4");
    access(32'h8080_0000 | (32'd1 << 13) | 32'h80, 0, 2, 0, "R4");
    access(32'h8080_0000 | (32'd1 << 20) | 32'h80, 0, 2, 0, "R4");
    access(32'h80BF_F87C, 1, 2, 32'h0, "R4");
    stall = 0;
    for (int b = 0; b < 4; b++) access(32'h8080_1100 + b, 1, 0, 32'h11 * (b + 1), "R2");
    for (int b = 0; b < 4; b++) access(32'h8080_1100 + b, 0, 0, 0, "R2");
    access(32'h8080_1100, 0, 2, 0, "R2");
    access(32'h8080_1202, 1, 1, 32'hBEEF, "R2");
    access(32'h8080_1200, 1, 1, 32'h7788, "R2");
    access(32'h8080_1202, 0, 1, 0, "R2");
    access(32'h8080_1201, 0, 1, 0, "R2");
    access(32'h8080_1200, 0, 3, 0, "R2");
    stall = 3;
    access(32'h807F_FFFC, 0, 2, 0, "R1");
    access(32'h80C0_0000, 1, 2, 32'hFFFF_FFFF, "R1");
    access(32'h0000_0800, 0, 2, 0, "R1");
    access(32'h80BF_FFFC, 0, 2, 0, "R3");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule